// File: doc/BRIEF.md
# Dispatch group slot allocator

This block takes up to four decoded operations per cycle from the head of an in-order window and packs them into one dispatch group. A group has five slots. Slots 0 to 3 take ordinary operations and slot 4 takes only a branch. For each slot it fills, the block names the execution unit instance the slot feeds. Where a class has two identical units, the slot position picks the unit.

Each window entry carries a valid bit, a cracked flag (the operation expands into two internal ops) and a 3-bit class code. The block returns a per-entry ready vector during the same cycle. Ready is always a prefix of the window. The first operation that cannot be placed closes the group and keeps its ready low, together with every operation after it. Upstream drops the accepted entries and shifts the rest forward. The group that is built is registered and appears on the outputs after the next clock edge.

Top module: `disp_group_alloc`

## Requirements
- R1: An active-high synchronous reset clears the registered group, so every grp_valid bit is 0 in the cycle after reset is sampled.
- R2: Operations are placed strictly in window order, and no operation takes a slot below one already used in the group. op_ready is combinational and is a prefix of the window. It goes low at the first operation that does not fit, and stays low for every operation after it.
- R3: Class codes are 0 integer, 1 load/store, 2 floating point, 3 branch, 4 serialising, 5 integer divide, 6 special-register move and 7 vector. Unit codes are 0 none, 1 integer A, 2 integer B, 3 load/store A, 4 load/store B, 5 FP A, 6 FP B, 7 vector and 8 branch unit. For integer, load/store and FP work, slots 0 and 3 feed unit A and slots 1 and 2 feed unit B. Each slot's unit sits in grp_unit[4*s+3:4*s].
- R4: A cracked operation of class 0, 1, 2 or 7 takes two adjacent slots in order, and can start only at slot 0, 1 or 2. The cracked flag has no effect on the other classes.
- R5: A serialising operation is accepted only when the group is still empty. It then takes slots 0 to 3, steered as load/store, and closes the group.
- R6: A branch always takes slot 4, feeds the branch unit and closes the group. Slot 4 never carries any other operation.
- R7: An integer divide goes only to slot 1 or 2, and so to integer B. It skips slot 0 when the group is empty. A special-register move goes only to slot 0 or 3, and so to integer A.
- R8: A window entry with a low valid bit ends placement at that entry. An empty window gives a group with no valid slots.
- R9: A vector operation may use any of slots 0 to 3 and feeds the vector unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 4 | Window entry valid, entry 0 oldest |
| op_crack | input | 4 | Entry expands into two internal ops |
| op_class | input | 12 | 3-bit class code per entry |
| op_ready | output | 4 | Entry accepted into the group this cycle |
| grp_valid | output | 5 | Registered per-slot valid |
| grp_unit | output | 20 | Registered 4-bit unit select per slot |

## Verification
A fault in the placement cursor shows at op_ready in the same cycle. It shows as ready dropping too early, or as ready being given to an operation that has no room. The same fault shows one clock later as a hole, an overlap or a shifted slot in grp_valid. A wrong steering decision shows one clock after acceptance, as an unexpected unit code in a slot. An example is divide work landing on integer A, or a slot-0 op landing on a B unit. Both ports are compared on every vector, so either kind of fault is seen within two cycles of the stimulus.

// File: rtl/disp_group_alloc.sv
module disp_group_alloc #(
  parameter int WIN   = 4,
  parameter int CLS_W = 3,
  parameter int UW    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIN-1:0]     op_valid,
  input  logic [WIN-1:0]     op_crack,
  input  logic [WIN*CLS_W-1:0] op_class,
  output logic [WIN-1:0]     op_ready,
  output logic [4:0]         grp_valid,
  output logic [5*UW-1:0]    grp_unit
);
  localparam int LANES = 4;
  localparam int SLOTS = LANES + 1;

  localparam logic [CLS_W-1:0] C_INT = 3'd0, C_LSU = 3'd1, C_FPU = 3'd2, C_BR = 3'd3,
                               C_SER = 3'd4, C_DIV = 3'd5, C_SPR = 3'd6, C_VEC = 3'd7;
  localparam logic [UW-1:0] U_IA = 4'd1, U_IB = 4'd2, U_LA = 4'd3, U_LB = 4'd4,
                            U_FA = 4'd5, U_FB = 4'd6, U_VU = 4'd7, U_BR = 4'd8;

  function automatic logic [UW-1:0] steer(input logic [CLS_W-1:0] c, input int s);
    logic a;
    a = (s == 0) || (s == 3);
    case (c)
      C_INT, C_DIV, C_SPR: steer = a ? U_IA : U_IB;
      C_LSU, C_SER:        steer = a ? U_LA : U_LB;
      C_FPU:               steer = a ? U_FA : U_FB;
      C_VEC:               steer = U_VU;
      default:             steer = U_BR;
    endcase
  endfunction

  logic [SLOTS-1:0]    nxt_v;
  logic [SLOTS*UW-1:0] nxt_u;
  logic [CLS_W-1:0]    cls;
  logic                take, stop;
  int                  pos, at, n;

  always_comb begin
    nxt_v = '0;
    nxt_u = '0;
    op_ready = '0;
    pos = 0;
    stop = 1'b0;
    cls = '0;
    take = 1'b0;
    at = 0;
    n = 0;
    for (int i = 0; i < WIN; i++) begin
      cls  = op_class[i*CLS_W +: CLS_W];
      take = 1'b0;
      at   = pos;
      n    = 1;
      if (!stop && op_valid[i]) begin
        case (cls)
          C_BR: begin
            take = 1'b1;
            n = 0;
            nxt_v[LANES] = 1'b1;
            nxt_u[LANES*UW +: UW] = U_BR;
          end
          C_SER: begin
            n = LANES;
            take = (pos == 0);
          end
          C_DIV: begin
            at = (pos == 0) ? 1 : pos;
            take = (pos <= 2);
          end
          C_SPR: begin
            at = (pos == 0) ? 0 : 3;
            take = (pos <= 3);
          end
          default: begin
            n = op_crack[i] ? 2 : 1;
            take = (pos + n <= LANES);
          end
        endcase
      end
      if (take) begin
        for (int k = 0; k < LANES; k++) begin
          if (k >= at && k < at + n) begin
            nxt_v[k] = 1'b1;
            nxt_u[k*UW +: UW] = steer(cls, k);
          end
        end
        pos = at + n;
        if (cls == C_BR || cls == C_SER) stop = 1'b1;
      end else begin
        stop = 1'b1;
      end
      op_ready[i] = take;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_valid <= '0;
      grp_unit  <= '0;
    end else begin
      grp_valid <= nxt_v;
      grp_unit  <= nxt_u;
    end
  end
endmodule

module disp_group_alloc_chk #(
  parameter int WIN = 4,
  parameter int UW  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [WIN-1:0] op_valid,
  input logic [WIN-1:0] op_ready,
  input logic [4:0]     grp_valid,
  input logic [5*UW-1:0] grp_unit
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (grp_valid == 5'b0));

  a_r6_branch_slot: assert property (@(posedge clk) disable iff (rst)
    grp_valid[4] |-> (grp_unit[4*UW +: UW] == 4'd8));

  generate
    for (genvar i = 0; i < WIN; i++) begin : g_op
      a_r8_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
        op_ready[i] |-> op_valid[i]);
      if (i > 0) begin : g_pre
        a_r2_ready_prefix: assert property (@(posedge clk) disable iff (rst)
          op_ready[i] |-> op_ready[i-1]);
      end
    end
    for (genvar s = 0; s < 4; s++) begin : g_slot
      a_r6_no_branch_low: assert property (@(posedge clk) disable iff (rst)
        grp_unit[s*UW +: UW] != 4'd8);
      a_r3_valid_matches_unit: assert property (@(posedge clk) disable iff (rst)
        grp_valid[s] == (grp_unit[s*UW +: UW] != 4'd0));
      if (s == 0 || s == 3) begin : g_a
        a_r7_outer_no_b: assert property (@(posedge clk) disable iff (rst)
          grp_unit[s*UW +: UW] != 4'd2);
      end else begin : g_b
        a_r7_inner_no_a: assert property (@(posedge clk) disable iff (rst)
          grp_unit[s*UW +: UW] != 4'd1);
      end
    end
  endgenerate
endmodule

bind disp_group_alloc disp_group_alloc_chk #(.WIN(WIN), .UW(UW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
  .grp_valid(grp_valid), .grp_unit(grp_unit));

// File: tb/disp_group_alloc_test.sv
module disp_group_alloc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_valid = '0, op_crack = '0, op_ready;
  logic [11:0] op_class = '0;
  logic [4:0]  grp_valid;
  logic [19:0] grp_unit;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  disp_group_alloc uut (.clk(clk), .rst(rst), .op_valid(op_valid), .op_crack(op_crack),
    .op_class(op_class), .op_ready(op_ready), .grp_valid(grp_valid), .grp_unit(grp_unit));

  localparam logic [4:0] N = 5'b00000, I = 5'b10000, IC = 5'b11000, L = 5'b10001,
    LC = 5'b11001, F = 5'b10010, FC = 5'b11010, B = 5'b10011, S = 5'b10100,
    D = 5'b10101, P = 5'b10110, V = 5'b10111;

  localparam int NV = 15;
  // {op3,op2,op1,op0, ready, valid, unit s4..s0}
  localparam logic [48:0] TBL [NV] = '{
    {I, I, I, I,    4'b1111, 5'b01111, 4'd0, 4'd1, 4'd2, 4'd2, 4'd1}, // R3 integer steering
    {B, I, I, I,    4'b1111, 5'b10111, 4'd8, 4'd0, 4'd2, 4'd2, 4'd1}, // R6 branch in slot 4
    {I, I, LC, FC,  4'b0011, 5'b01111, 4'd0, 4'd3, 4'd4, 4'd6, 4'd5}, // R4 cracked pairs
    {B, IC, IC, I,  4'b0011, 5'b00111, 4'd0, 4'd0, 4'd2, 4'd2, 4'd1}, // R4 no start at slot 3, R2 hold
    {N, N, I, S,    4'b0001, 5'b01111, 4'd0, 4'd3, 4'd4, 4'd4, 4'd3}, // R5 serialising alone
    {N, N, S, I,    4'b0001, 5'b00001, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1}, // R5 needs empty group
    {N, N, I, B,    4'b0001, 5'b10000, 4'd8, 4'd0, 4'd0, 4'd0, 4'd0}, // R6 closes group
    {I, P, I, D,    4'b0111, 5'b01110, 4'd0, 4'd1, 4'd2, 4'd2, 4'd0}, // R7 divide skips slot 0
    {P, D, I, I,    4'b1111, 5'b01111, 4'd0, 4'd1, 4'd2, 4'd2, 4'd1}, // R7 divide at slot 2
    {D, I, I, I,    4'b0111, 5'b00111, 4'd0, 4'd0, 4'd2, 4'd2, 4'd1}, // R7 divide cannot use slot 3
    {N, I, P, P,    4'b0011, 5'b01001, 4'd0, 4'd1, 4'd0, 4'd0, 4'd1}, // R7 move jumps to slot 3
    {N, L, F, V,    4'b0111, 5'b00111, 4'd0, 4'd0, 4'd4, 4'd6, 4'd7}, // R9 vector, R3 lsu/fp
    {N, N, N, N,    4'b0000, 5'b00000, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0}, // R8 empty window
    {N, I, N, I,    4'b0001, 5'b00001, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1}, // R8 gap stops placement
    {N, B, IC, L,   4'b0111, 5'b10111, 4'd8, 4'd0, 4'd2, 4'd2, 4'd3}  // R4 R6 mixed
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [19:0] ops);
    for (int k = 0; k < 4; k++) begin
      op_valid[k] = ops[5*k+4];
      op_crack[k] = ops[5*k+3];
      op_class[3*k +: 3] = ops[5*k +: 3];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state valid", {27'd0, grp_valid}, 32'd0);
    chk("R1 reset state unit", {12'd0, grp_unit}, 32'd0);
    rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(TBL[v][48:29]);
      #1;
      chk($sformatf("R2 ready vec %0d", v), {28'd0, op_ready}, {28'd0, TBL[v][28:25]});
      @(negedge clk);
      chk($sformatf("R4 slot valid vec %0d", v), {27'd0, grp_valid}, {27'd0, TBL[v][24:20]});
      chk($sformatf("R3 unit vec %0d", v), {12'd0, grp_unit}, {12'd0, TBL[v][19:0]});
    end
    // R1: reset while a full window is offered
    @(negedge clk);
    drive({I, I, I, I});
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset valid", {27'd0, grp_valid}, 32'd0);
    rst = 1'b0;
    drive({N, N, N, N});
    @(negedge clk);
    chk("R8 idle after reset", {27'd0, grp_valid}, 32'd0);
    // R4: cracked flag ignored on divide, R7
    drive({N, N, N, D | 5'b01000});
    #1;
    chk("R4 crack ignored ready", {28'd0, op_ready}, 32'd1);
    @(negedge clk);
    chk("R4 crack ignored valid", {27'd0, grp_valid}, 32'b00010);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule